// File: doc/BRIEF.md
# Periodic Sensor-Sample Encryption Sequencer

This block samples an analog-to-digital converter at a fixed interval and has each reading encrypted, with no software involved. A free-running interval timer raises a tick once every `PERIOD_CYCLES` clocks. On a tick, the controller asks the converter for a reading and waits for the converter's ready strobe. It then widens the 12-bit reading to a 128-bit plaintext, with the reading in the low bits and zeros above it. The controller starts the external block cipher in encrypt mode and waits for the cipher's done strobe.

When the cipher reports done, the ciphertext is copied into a result buffer. A valid flag is raised so that a downstream serial transmitter can pick the ciphertext up, and a running sample count is advanced. The converter, the cipher core and the transmitter are all outside this block. The default interval is five seconds at 125 MHz. Simulation shortens the interval through the parameter.

Top module: `sample_crypt_seq`

## Requirements
- R1: The interval timer counts from the end of reset. A tick occurs on the clock edge that completes every `PERIOD_CYCLES`-th cycle. A tick that finds the sequencer idle raises `adc_req` for exactly the one cycle that follows that edge.
- R2: A tick that occurs while a sample is in progress is dropped, not queued. This includes the cycle after a result is stored. A dropped tick never produces a later `adc_req`.
- R3: The reading on `adc_data` is captured only on the edge where `adc_rdy` is high. `aes_din` carries that reading in bits 11:0, and bits 127:12 are zero.
- R4: One cycle after the edge that captured the reading, `aes_start` is high for exactly one cycle. `aes_encrypt` is 1 in that cycle.
- R5: After a start, the sequencer issues no further `aes_start` and no `adc_req` until `aes_done` has been seen.
- R6: On the edge where `aes_done` is high, `aes_dout` is copied into `res_data`. In the following cycle `res_valid` reads 1, and any older result is overwritten.
- R7: `res_valid` stays high until an edge where `res_take` is high and `aes_done` is low. It then reads 0.
- R8: If `res_take` and `aes_done` are high on the same edge, the new result wins and `res_valid` stays 1.
- R9: `sample_cnt` advances by one for each stored result and wraps to zero after its all-ones value.
- R10: While `rst_n` is low, `adc_req`, `aes_start`, `res_valid`, `res_data` and `sample_cnt` are all zero after each clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| adc_req | output | 1 | One-cycle request for a new reading |
| adc_rdy | input | 1 | Converter strobe: `adc_data` is valid |
| adc_data | input | SAMPLE_W | Converter reading |
| aes_start | output | 1 | One-cycle start pulse to the cipher |
| aes_encrypt | output | 1 | Cipher direction, 1 means encrypt |
| aes_din | output | BLOCK_W | Zero-extended plaintext block |
| aes_done | input | 1 | Cipher strobe: `aes_dout` is valid |
| aes_dout | input | BLOCK_W | Ciphertext from the cipher |
| res_valid | output | 1 | Buffered ciphertext awaits pickup |
| res_data | output | BLOCK_W | Buffered ciphertext |
| res_take | input | 1 | Downstream consume pulse |
| sample_cnt | output | COUNT_W | Count of stored results |

## Verification
Each result has a fixed due cycle, counted from the edge that caused it:
- `adc_req` is due in the cycle after an accepted tick.
- `aes_start` is due in the cycle after the edge that carried `adc_rdy`.
- `res_valid`, `res_data` and `sample_cnt` change in the cycle after the edge that carried `aes_done`.
- The clearing of `res_valid` is due in the cycle after a lone `res_take`.

The bench keeps its own timer and busy flag, and updates them at the falling edge for the rising edge just passed. It then compares every output in that same half-cycle. The converter and cipher stubs answer with latencies chosen per sample. Some samples outlast the interval and force dropped ticks. One stub delivers done and take on the same edge.

// File: rtl/sample_crypt_seq_pkg.sv
// Shared types for the periodic sample-encryption sequencer.
package sample_crypt_seq_pkg;

    // Sequencer phases, in the order a sample passes through them.
    typedef enum logic [2:0] {
        IDLE_WAIT = 3'd0,
        ADC_REQ   = 3'd1,
        ADC_WAIT  = 3'd2,
        AES_START = 3'd3,
        AES_WAIT  = 3'd4,
        STORE     = 3'd5
    } seq_state_t;

endpackage

// File: rtl/interval_timer.sv
// Free-running interval timer.
// Raises tick for one cycle in every PERIOD_CYCLES cycles. The first tick
// comes PERIOD_CYCLES cycles after reset is released.
// Assumes PERIOD_CYCLES >= 2.
module interval_timer #(
    parameter int unsigned PERIOD_CYCLES = 625_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned TW = $clog2(PERIOD_CYCLES);
    localparam logic [TW-1:0] LAST = TW'(PERIOD_CYCLES - 1);

    logic [TW-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    // Count up, and restart at zero on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/seq_ctrl.sv
// Sample sequencer control.
// Walks one sample through the converter and cipher handshakes. Holds the
// captured reading, and signals store_en on the edge where the cipher
// reports done. Ticks are accepted only in IDLE_WAIT; any other tick is lost.
// Assumes adc_rdy and aes_done come only in reply to this block's requests.
module seq_ctrl
    import sample_crypt_seq_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 12,
    parameter int unsigned BLOCK_W  = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                adc_rdy,
    input  logic [SAMPLE_W-1:0] adc_data,
    input  logic                aes_done,
    output logic                adc_req,
    output logic                aes_start,
    output logic                aes_encrypt,
    output logic [BLOCK_W-1:0]  aes_din,
    output logic                store_en
);
    localparam int unsigned PAD_W = BLOCK_W - SAMPLE_W;

    seq_state_t          state_q, state_d;
    logic [SAMPLE_W-1:0] sample_q;

    // Next-phase selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IDLE_WAIT: if (tick) state_d = ADC_REQ;
            ADC_REQ:   state_d = ADC_WAIT;
            ADC_WAIT:  if (adc_rdy) state_d = AES_START;
            AES_START: state_d = AES_WAIT;
            AES_WAIT:  if (aes_done) state_d = STORE;
            STORE:     state_d = IDLE_WAIT;
            default:   state_d = IDLE_WAIT;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IDLE_WAIT;
        else        state_q <= state_d;
    end

    // Capture the reading only while waiting for it.
    always_ff @(posedge clk) begin
        if (!rst_n)                            sample_q <= '0;
        else if (state_q == ADC_WAIT && adc_rdy) sample_q <= adc_data;
    end

    assign adc_req     = (state_q == ADC_REQ);
    assign aes_start   = (state_q == AES_START);
    assign aes_encrypt = (state_q == AES_START) || (state_q == AES_WAIT);
    assign aes_din     = {{PAD_W{1'b0}}, sample_q};
    assign store_en    = (state_q == AES_WAIT) && aes_done;
endmodule

// File: rtl/result_hold.sv
// Result buffer with a valid flag and a wrapping sample counter.
// A load overwrites the buffer, sets valid and advances the count. A take
// clears valid unless a load happens on the same edge.
module result_hold #(
    parameter int unsigned BLOCK_W = 128,
    parameter int unsigned COUNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [BLOCK_W-1:0] din,
    input  logic               take,
    output logic               valid,
    output logic [BLOCK_W-1:0] data,
    output logic [COUNT_W-1:0] count
);
    // Buffer the ciphertext on each load.
    always_ff @(posedge clk) begin
        if (!rst_n)    data <= '0;
        else if (load) data <= din;
    end

    // Valid flag: a load has priority over a take.
    always_ff @(posedge clk) begin
        if (!rst_n)    valid <= 1'b0;
        else if (load) valid <= 1'b1;
        else if (take) valid <= 1'b0;
    end

    // Count stored results, wrapping naturally.
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (load) count <= count + 1'b1;
    end
endmodule

// File: rtl/sample_crypt_seq.sv
// Periodic sensor-sample encryption sequencer (top).
// Ties together the interval timer, the sample sequencer and the result
// buffer. The converter, cipher and transmitter are outside this block.
module sample_crypt_seq #(
    parameter int unsigned PERIOD_CYCLES = 625_000_000,
    parameter int unsigned SAMPLE_W      = 12,
    parameter int unsigned BLOCK_W       = 128,
    parameter int unsigned COUNT_W       = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic                adc_req,
    input  logic                adc_rdy,
    input  logic [SAMPLE_W-1:0] adc_data,
    output logic                aes_start,
    output logic                aes_encrypt,
    output logic [BLOCK_W-1:0]  aes_din,
    input  logic                aes_done,
    input  logic [BLOCK_W-1:0]  aes_dout,
    output logic                res_valid,
    output logic [BLOCK_W-1:0]  res_data,
    input  logic                res_take,
    output logic [COUNT_W-1:0]  sample_cnt
);
    logic tick;
    logic store_en;

    interval_timer #(.PERIOD_CYCLES(PERIOD_CYCLES)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    seq_ctrl #(.SAMPLE_W(SAMPLE_W), .BLOCK_W(BLOCK_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .adc_rdy    (adc_rdy),
        .adc_data   (adc_data),
        .aes_done   (aes_done),
        .adc_req    (adc_req),
        .aes_start  (aes_start),
        .aes_encrypt(aes_encrypt),
        .aes_din    (aes_din),
        .store_en   (store_en)
    );

    result_hold #(.BLOCK_W(BLOCK_W), .COUNT_W(COUNT_W)) u_hold (
        .clk  (clk),
        .rst_n(rst_n),
        .load (store_en),
        .din  (aes_dout),
        .take (res_take),
        .valid(res_valid),
        .data (res_data),
        .count(sample_cnt)
    );
endmodule

// File: rtl/sample_crypt_seq_chk.sv
// Port-level property checker for sample_crypt_seq, attached by bind.
module sample_crypt_seq_chk #(
    parameter int unsigned SAMPLE_W = 12,
    parameter int unsigned BLOCK_W  = 128,
    parameter int unsigned COUNT_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               adc_req,
    input logic               aes_start,
    input logic               aes_encrypt,
    input logic [BLOCK_W-1:0] aes_din,
    input logic               aes_done,
    input logic               res_valid,
    input logic               res_take,
    input logic [COUNT_W-1:0] sample_cnt
);
    a_r1_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        adc_req |=> !adc_req);

    a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        aes_start |=> !aes_start);

    a_r4_start_encrypts: assert property (@(posedge clk) disable iff (!rst_n)
        aes_start |-> aes_encrypt);

    a_r3_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        aes_start |-> (aes_din[BLOCK_W-1:SAMPLE_W] == '0));

    a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (aes_start && !aes_done) |=> !adc_req);

    a_r7_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_take) |=> res_valid);

    a_r8_done_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (aes_done && res_take && aes_encrypt) |=> res_valid);

    a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_cnt != $past(sample_cnt)) |-> (sample_cnt == $past(sample_cnt) + 1'b1));

    a_r6_count_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_cnt != $past(sample_cnt)) |-> res_valid);
endmodule

bind sample_crypt_seq sample_crypt_seq_chk #(
    .SAMPLE_W(SAMPLE_W), .BLOCK_W(BLOCK_W), .COUNT_W(COUNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .adc_req    (adc_req),
    .aes_start  (aes_start),
    .aes_encrypt(aes_encrypt),
    .aes_din    (aes_din),
    .aes_done   (aes_done),
    .res_valid  (res_valid),
    .res_take   (res_take),
    .sample_cnt (sample_cnt)
);

// File: tb/sample_crypt_seq_bench.sv
// Bench: behavioural timer/busy model, converter and cipher stubs, per-cycle compare.
module sample_crypt_seq_bench;
    localparam int unsigned PERIOD = 40;
    localparam int unsigned SW = 12;
    localparam int unsigned BW = 128;
    localparam int unsigned CW = 3;
    localparam int RUN_CYCLES = 3000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          adc_req, adc_rdy = 1'b0;
    logic [SW-1:0] adc_data = '0;
    logic          aes_start, aes_encrypt;
    logic [BW-1:0] aes_din;
    logic          aes_done = 1'b0;
    logic [BW-1:0] aes_dout = '0;
    logic          res_valid;
    logic [BW-1:0] res_data;
    logic          res_take = 1'b0;
    logic [CW-1:0] sample_cnt;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    sample_crypt_seq #(
        .PERIOD_CYCLES(PERIOD), .SAMPLE_W(SW), .BLOCK_W(BW), .COUNT_W(CW)
    ) u_sample_crypt_seq (
        .clk(clk), .rst_n(rst_n),
        .adc_req(adc_req), .adc_rdy(adc_rdy), .adc_data(adc_data),
        .aes_start(aes_start), .aes_encrypt(aes_encrypt), .aes_din(aes_din),
        .aes_done(aes_done), .aes_dout(aes_dout),
        .res_valid(res_valid), .res_data(res_data), .res_take(res_take),
        .sample_cnt(sample_cnt)
    );

    task automatic chk(input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [SW-1:0] smp(input int i);
        case (i % 6)
            0: return 12'h000;
            1: return 12'hFFF;
            2: return 12'h800;
            3: return 12'h001;
            default: return SW'(i * 935) ^ 12'h5C3;
        endcase
    endfunction

    function automatic logic [BW-1:0] cipher(input logic [BW-1:0] pt);
        return {4{pt[31:0]}} ^ 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;
    endfunction

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int tcnt = 0;
        int phase = 0;          // 0 idle, 1 busy, 2 store cycle
        int sidx = 0;
        int adc_cd = -1;
        int aes_cd = -1;
        int drops = 0;
        int wraps = 0;
        logic [SW-1:0] cur_s = '0;
        logic [BW-1:0] cur_ct = '0;
        logic exp_req = 0, exp_start = 0, exp_valid = 0;
        logic [BW-1:0] exp_data = '0;
        logic [CW-1:0] exp_cnt = '0;

        // R10: reset state.
        repeat (3) @(negedge clk);
        chk("R10 adc_req", BW'(adc_req), '0);
        chk("R10 aes_start", BW'(aes_start), '0);
        chk("R10 res_valid", BW'(res_valid), '0);
        chk("R10 res_data", res_data, '0);
        chk("R10 sample_cnt", BW'(sample_cnt), '0);
        rst_n = 1'b1;

        for (int cyc = 0; cyc < RUN_CYCLES; cyc++) begin
            logic tk;
            @(posedge clk);
            @(negedge clk);
            // Model the edge just passed, using the inputs applied over it.
            tk = (tcnt == PERIOD - 1);
            tcnt = tk ? 0 : tcnt + 1;
            exp_req = 1'b0;
            if (phase == 2) begin
                phase = 0;
                if (tk) drops++;
            end else if (phase == 0 && tk) begin
                phase = 1;
                exp_req = 1'b1;
            end else if (tk) drops++;
            exp_start = adc_rdy;
            if (aes_done) begin
                exp_data = cur_ct;
                exp_valid = 1'b1;
                if (exp_cnt == '1) wraps++;
                exp_cnt = exp_cnt + 1'b1;
                phase = 2;
                sidx++;
            end else if (res_take) exp_valid = 1'b0;

            chk("R1/R2/R5 adc_req", BW'(adc_req), BW'(exp_req));
            chk("R4/R5 aes_start", BW'(aes_start), BW'(exp_start));
            chk("R6/R7/R8 res_valid", BW'(res_valid), BW'(exp_valid));
            chk("R6 res_data", res_data, exp_data);
            chk("R9 sample_cnt", BW'(sample_cnt), BW'(exp_cnt));

            // Converter stub.
            adc_rdy = 1'b0;
            if (adc_cd > 0) adc_cd--;
            if (adc_cd == 0) begin
                adc_rdy = 1'b1;
                adc_cd = -1;
            end
            if (adc_req) begin
                cur_s = smp(sidx);
                adc_cd = (sidx % 3 == 0) ? 26 : (sidx % 3 == 1) ? 2 : 9;
            end
            adc_data = adc_rdy ? cur_s : ~cur_s;

            // Cipher stub.
            aes_done = 1'b0;
            if (aes_cd > 0) aes_cd--;
            if (aes_cd == 0) begin
                aes_done = 1'b1;
                aes_cd = -1;
            end
            if (aes_start) begin
                chk("R3 aes_din padding", aes_din, {{(BW-SW){1'b0}}, cur_s});
                chk("R4 aes_encrypt", BW'(aes_encrypt), BW'(1));
                cur_ct = cipher(aes_din);
                aes_cd = (sidx % 2 == 0) ? 11 : 1;
            end
            aes_dout = aes_done ? cur_ct : ~cur_ct;

            // Downstream consumer; R8 same-edge case every fourth sample.
            res_take = (cyc % 23 == 0) || (aes_done && (sidx % 4 == 1));
        end

        chk("R2 dropped ticks occurred", BW'(drops > 0), BW'(1));
        chk("R9 counter wrapped", BW'(wraps > 0), BW'(1));
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule